// File: doc/BRIEF.md
# USB Device Endpoint Buffer Handshake Controller

This block keeps the ownership state of the packet buffers behind up to sixteen device-side USB endpoints. For each endpoint it knows whether the buffer is empty or holds a packet, how long that packet is, and whether an endpoint event is waiting for the processor. The bus side reports finished receive and transmit transactions with one-cycle strobes. From that state the block drives one ready line per endpoint, and the bus side answers NAK when that line is low. The data bytes themselves live elsewhere. Here a packet appears only as its length.

The processor drives a command stream that uses valid/ready. Each command carries an opcode, an endpoint index and a length/data field. Opcodes 1 and 2 return a status word on a separate response stream, which also uses valid/ready. Only one response can be outstanding: `cmd_ready` is `!rsp_valid || rsp_ready`, so the command stream stalls while a response waits. The response stays stable until the consumer takes it. Endpoint 0 is the control OUT endpoint and endpoint 1 is the control IN endpoint. Both are always enabled. When a set-up packet arrives on endpoint 0, both control endpoints are locked until the processor acknowledges each of them.

Top module: `usb_ep_handshake`

## Requirements
- R1: After `rst_n` low, or after a cycle with `bus_rst` high, endpoints 2..15 are disabled, every endpoint is empty with length 0 and no pending interrupt, both control locks are off, and `ep_ready` is 16'h0001. Endpoint 0 stays enabled as OUT and endpoint 1 stays enabled as IN.
- R2: Opcode 0 (configure) applies only to endpoints 2..15. It sets enable from `cmd_len[0]` and direction from `cmd_len[1]` (1 = IN/transmit). It also empties the buffer, zeroes the length and clears the interrupt.
- R3: A `rx_pkt` strobe without `rx_setup` is accepted only by an enabled, empty, unlocked OUT endpoint. Acceptance sets full, stores `rx_len` and raises the interrupt. While the buffer is full, further packets are ignored. Opcode 3 (clear) empties the buffer and zeroes the length.
- R4: On an IN endpoint, opcode 6 (write length) stores `cmd_len` only while the buffer is empty. Opcode 4 (validate) marks the buffer full. A `tx_done` strobe on a full, unlocked IN endpoint empties it and raises the interrupt.
- R5: `ep_ready[i]` is high for an enabled, unlocked endpoint that is either an empty OUT endpoint or a full IN endpoint. It is low in every other case.
- R6: Opcode 2 (status) returns `{setup, enabled, is_in, locked, irq, full, len[9:0]}` (bit 15 down to bit 0) from the state before the command and clears the interrupt. Opcode 1 (select) returns the same word without clearing anything. An event that raises the interrupt in the same cycle takes precedence over the clear.
- R7: A `rx_pkt` with `rx_setup` on endpoint 0 while endpoint 0 is unlocked stores the length, sets full, irq and the setup flag on endpoint 0, flushes endpoint 1 (empty, length 0), and locks both control endpoints. The same strobe on any other endpoint, or while endpoint 0 is locked, is ignored.
- R8: While a control endpoint is locked, clear and validate on it are rejected, endpoint 0 accepts no packet, endpoint 1 sends nothing, and its ready line is low.
- R9: Opcode 5 (acknowledge set-up) on endpoint 0 or 1 unlocks only that endpoint. On any other endpoint it is rejected.
- R10: `cmd_err` pulses for exactly one cycle after each accepted command that is rejected, and the command has no effect. A command is rejected when it targets a disabled endpoint, configures endpoint 0 or 1, writes a length to an OUT endpoint or to a full endpoint, validates an OUT endpoint, or uses opcode 7. The locked and acknowledge cases are given in R8 and R9.
- R11: Command effects, `cmd_err` and `rsp_valid` appear one cycle after acceptance. A pending response and its status word stay unchanged until `rsp_ready` is high.
- R12: Bus events are judged against the state before the clock edge. When a bus event and a command touch the same endpoint in the same cycle, the bus event's updates of full, length and irq win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rst | input | 1 | Synchronous USB bus reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high with valid |
| cmd_op | input | 3 | Opcode (0 configure, 1 select, 2 status, 3 clear, 4 validate, 5 acknowledge set-up, 6 write length, 7 reserved) |
| cmd_ep | input | 4 | Endpoint index |
| cmd_len | input | 10 | Length, or configuration bits for opcode 0 |
| rsp_valid | output | 1 | Status response valid |
| rsp_ready | input | 1 | Status response taken |
| rsp_status | output | 16 | Status word, layout in R6 |
| cmd_err | output | 1 | One-cycle rejection pulse |
| rx_pkt | input | 1 | Packet received strobe |
| rx_ep | input | 4 | Endpoint of received packet |
| rx_setup | input | 1 | Received packet is a set-up packet |
| rx_len | input | 10 | Received packet length |
| tx_done | input | 1 | Packet sent strobe |
| tx_ep | input | 4 | Endpoint of sent packet |
| ep_ready | output | 16 | Per-endpoint ready (low means NAK) |

## Verification
The assertions assume that `rst_n` is low from time zero for at least one edge and that `cmd_valid` stays low during reset. The property on acknowledge excludes cycles in which a set-up strobe also arrives, because the set-up takes precedence. The bench holds its inputs inactive through reset and then drives every input at the falling edge. A behavioural model judges each cycle from the pre-edge state. The random phase sometimes sends strobes to disabled, full or locked endpoints, so the ignore paths are covered, and it keeps every endpoint index inside 0..15.

// File: rtl/usb_ephs_pkg.sv
package usb_ephs_pkg;
  typedef enum logic [2:0] {
    OP_CFG  = 3'd0,
    OP_SEL  = 3'd1,
    OP_STAT = 3'd2,
    OP_CLR  = 3'd3,
    OP_VAL  = 3'd4,
    OP_ACK  = 3'd5,
    OP_WLEN = 3'd6,
    OP_RSV  = 3'd7
  } ephs_op_e;

  localparam int unsigned CTRL_OUT_EP = 0;
  localparam int unsigned CTRL_IN_EP  = 1;
endpackage

// File: rtl/ephs_ep_slot.sv
module ephs_ep_slot #(
  parameter int unsigned LEN_W    = 10,
  parameter bit          FIXED    = 1'b0,
  parameter bit          FIXED_IN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             cfg_go,
  input  logic             cfg_en,
  input  logic             cfg_in,
  input  logic             stat_go,
  input  logic             clr_go,
  input  logic             val_go,
  input  logic             wlen_go,
  input  logic [LEN_W-1:0] wlen_val,
  input  logic             lock,
  input  logic             rx_sel,
  input  logic             setup_go,
  input  logic             flush_go,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             tx_sel,
  output logic             en_o,
  output logic             in_o,
  output logic             full_o,
  output logic             irq_o,
  output logic             setup_o,
  output logic [LEN_W-1:0] len_o,
  output logic             ready_o
);
  logic             en_q, in_q, full_q, irq_q, setup_q;
  logic [LEN_W-1:0] len_q;
  logic             en_n, in_n, full_n, irq_n, setup_n;
  logic [LEN_W-1:0] len_n;
  logic             rx_go, tx_go;

  // bus acceptance judged on registered state only
  assign rx_go = rx_sel && en_q && !in_q && !full_q && !lock;
  assign tx_go = tx_sel && en_q && in_q && full_q && !lock;

  always_comb begin
    en_n    = en_q;
    in_n    = in_q;
    full_n  = full_q;
    irq_n   = irq_q;
    setup_n = setup_q;
    len_n   = len_q;
    // processor commands first
    if (cfg_go) begin
      en_n    = cfg_en;
      in_n    = cfg_in;
      full_n  = 1'b0;
      irq_n   = 1'b0;
      setup_n = 1'b0;
      len_n   = '0;
    end
    if (stat_go) irq_n = 1'b0;
    if (clr_go) begin
      full_n  = 1'b0;
      setup_n = 1'b0;
      len_n   = '0;
    end
    if (val_go)  full_n = 1'b1;
    if (wlen_go) len_n  = wlen_val;
    // bus events override
    if (setup_go) begin
      full_n  = 1'b1;
      irq_n   = 1'b1;
      setup_n = 1'b1;
      len_n   = rx_len;
    end
    if (flush_go) begin
      full_n = 1'b0;
      len_n  = '0;
    end
    if (rx_go) begin
      full_n = 1'b1;
      irq_n  = 1'b1;
      len_n  = rx_len;
    end
    if (tx_go) begin
      full_n = 1'b0;
      irq_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= FIXED;
      in_q    <= FIXED_IN;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
      setup_q <= 1'b0;
      len_q   <= '0;
    end else if (bus_rst) begin
      en_q    <= FIXED;
      in_q    <= FIXED_IN;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
      setup_q <= 1'b0;
      len_q   <= '0;
    end else begin
      en_q    <= en_n;
      in_q    <= in_n;
      full_q  <= full_n;
      irq_q   <= irq_n;
      setup_q <= setup_n;
      len_q   <= len_n;
    end
  end

  assign en_o    = en_q;
  assign in_o    = in_q;
  assign full_o  = full_q;
  assign irq_o   = irq_q;
  assign setup_o = setup_q;
  assign len_o   = len_q;
  assign ready_o = en_q && !lock && (in_q ? full_q : !full_q);
endmodule

// File: rtl/ephs_setup_lock.sv
module ephs_setup_lock (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       setup_go,
  input  logic [1:0] ack_go,
  output logic [1:0] lock_o
);
  logic [1:0] lock_q;

  for (genvar k = 0; k < 2; k++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            lock_q[k] <= 1'b0;
      else if (bus_rst)      lock_q[k] <= 1'b0;
      else if (setup_go)     lock_q[k] <= 1'b1;
      else if (ack_go[k])    lock_q[k] <= 1'b0;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/ephs_cmd_ctrl.sv
module ephs_cmd_ctrl
  import usb_ephs_pkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned LEN_W  = 10,
  localparam int unsigned EP_W  = $clog2(NUM_EP),
  localparam int unsigned RSP_W = LEN_W + 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [2:0]                  cmd_op,
  input  logic [EP_W-1:0]             cmd_ep,
  input  logic                        rsp_ready,
  output logic                        rsp_valid,
  output logic [RSP_W-1:0]            rsp_status,
  output logic                        cmd_err,
  input  logic [NUM_EP-1:0]           en_v,
  input  logic [NUM_EP-1:0]           in_v,
  input  logic [NUM_EP-1:0]           full_v,
  input  logic [NUM_EP-1:0]           irq_v,
  input  logic [NUM_EP-1:0]           setup_v,
  input  logic [NUM_EP-1:0]           lock_v,
  input  logic [NUM_EP-1:0][LEN_W-1:0] len_v,
  output logic [NUM_EP-1:0]           cfg_go_v,
  output logic [NUM_EP-1:0]           stat_go_v,
  output logic [NUM_EP-1:0]           clr_go_v,
  output logic [NUM_EP-1:0]           val_go_v,
  output logic [NUM_EP-1:0]           wlen_go_v,
  output logic [1:0]                  ack_go
);
  logic              accept, hit, ok;
  logic              en_t, in_t, full_t, lk_t;
  logic [NUM_EP-1:0] onehot;
  ephs_op_e          op;
  logic              rsp_valid_q, err_q;
  logic [RSP_W-1:0]  rsp_q;

  assign op        = ephs_op_e'(cmd_op);
  assign cmd_ready = !rsp_valid_q || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign hit       = (32'(cmd_ep) < NUM_EP);
  assign onehot    = hit ? (NUM_EP'(1) << cmd_ep) : '0;
  assign en_t      = hit && en_v[cmd_ep];
  assign in_t      = hit && in_v[cmd_ep];
  assign full_t    = hit && full_v[cmd_ep];
  assign lk_t      = hit && lock_v[cmd_ep];

  always_comb begin
    unique case (op)
      OP_CFG:          ok = hit && (32'(cmd_ep) > CTRL_IN_EP);
      OP_SEL, OP_STAT: ok = en_t;
      OP_CLR:          ok = en_t && !lk_t;
      OP_VAL:          ok = en_t && in_t && !lk_t;
      OP_WLEN:         ok = en_t && in_t && !full_t;
      OP_ACK:          ok = (32'(cmd_ep) <= CTRL_IN_EP);
      default:         ok = 1'b0;
    endcase
  end

  assign cfg_go_v  = (accept && ok && op == OP_CFG)  ? onehot : '0;
  assign stat_go_v = (accept && ok && op == OP_STAT) ? onehot : '0;
  assign clr_go_v  = (accept && ok && op == OP_CLR)  ? onehot : '0;
  assign val_go_v  = (accept && ok && op == OP_VAL)  ? onehot : '0;
  assign wlen_go_v = (accept && ok && op == OP_WLEN) ? onehot : '0;
  assign ack_go    = (accept && ok && op == OP_ACK)  ? onehot[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_q       <= '0;
      err_q       <= 1'b0;
    end else begin
      err_q <= accept && !ok;
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      if (accept && ok && (op == OP_SEL || op == OP_STAT)) begin
        rsp_valid_q <= 1'b1;
        rsp_q <= {setup_v[cmd_ep], en_v[cmd_ep], in_v[cmd_ep], lock_v[cmd_ep],
                  irq_v[cmd_ep], full_v[cmd_ep], len_v[cmd_ep]};
      end
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_q;
  assign cmd_err    = err_q;
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import usb_ephs_pkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned LEN_W  = 10,
  localparam int unsigned EP_W  = $clog2(NUM_EP),
  localparam int unsigned RSP_W = LEN_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [EP_W-1:0]   cmd_ep,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [RSP_W-1:0]  rsp_status,
  output logic              cmd_err,
  input  logic              rx_pkt,
  input  logic [EP_W-1:0]   rx_ep,
  input  logic              rx_setup,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              tx_done,
  input  logic [EP_W-1:0]   tx_ep,
  output logic [NUM_EP-1:0] ep_ready
);
  logic [NUM_EP-1:0]            en_v, in_v, full_v, irq_v, setup_v, lock_v;
  logic [NUM_EP-1:0][LEN_W-1:0] len_v;
  logic [NUM_EP-1:0]            cfg_go_v, stat_go_v, clr_go_v, val_go_v, wlen_go_v;
  logic [1:0]                   ack_go, lock_q;
  logic                         setup_go;

  assign setup_go = rx_pkt && rx_setup && (32'(rx_ep) == CTRL_OUT_EP) && !lock_q[0];
  assign lock_v   = {{(NUM_EP-2){1'b0}}, lock_q};

  ephs_setup_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rst  (bus_rst),
    .setup_go (setup_go),
    .ack_go   (ack_go),
    .lock_o   (lock_q)
  );

  ephs_cmd_ctrl #(.NUM_EP(NUM_EP), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_ep     (cmd_ep),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .cmd_err    (cmd_err),
    .en_v       (en_v),
    .in_v       (in_v),
    .full_v     (full_v),
    .irq_v      (irq_v),
    .setup_v    (setup_v),
    .lock_v     (lock_v),
    .len_v      (len_v),
    .cfg_go_v   (cfg_go_v),
    .stat_go_v  (stat_go_v),
    .clr_go_v   (clr_go_v),
    .val_go_v   (val_go_v),
    .wlen_go_v  (wlen_go_v),
    .ack_go     (ack_go)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    localparam bit IS_FIXED = (i <= CTRL_IN_EP);
    localparam bit IS_CIN   = (i == CTRL_IN_EP);
    logic rx_sel_i, tx_sel_i;
    assign rx_sel_i = rx_pkt && !rx_setup && (32'(rx_ep) == i);
    assign tx_sel_i = tx_done && (32'(tx_ep) == i);

    ephs_ep_slot #(.LEN_W(LEN_W), .FIXED(IS_FIXED), .FIXED_IN(IS_CIN)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_rst  (bus_rst),
      .cfg_go   (cfg_go_v[i]),
      .cfg_en   (cmd_len[0]),
      .cfg_in   (cmd_len[1]),
      .stat_go  (stat_go_v[i]),
      .clr_go   (clr_go_v[i]),
      .val_go   (val_go_v[i]),
      .wlen_go  (wlen_go_v[i]),
      .wlen_val (cmd_len),
      .lock     (lock_v[i]),
      .rx_sel   (rx_sel_i),
      .setup_go ((i == CTRL_OUT_EP) ? setup_go : 1'b0),
      .flush_go ((i == CTRL_IN_EP) ? setup_go : 1'b0),
      .rx_len   (rx_len),
      .tx_sel   (tx_sel_i),
      .en_o     (en_v[i]),
      .in_o     (in_v[i]),
      .full_o   (full_v[i]),
      .irq_o    (irq_v[i]),
      .setup_o  (setup_v[i]),
      .len_o    (len_v[i]),
      .ready_o  (ep_ready[i])
    );
  end
endmodule

// File: rtl/ephs_checker.sv
module ephs_checker
  import usb_ephs_pkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned LEN_W  = 10,
  localparam int unsigned EP_W  = $clog2(NUM_EP),
  localparam int unsigned RSP_W = LEN_W + 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [EP_W-1:0]   cmd_ep,
  input logic              cmd_err,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [RSP_W-1:0]  rsp_status,
  input logic              rx_pkt,
  input logic [EP_W-1:0]   rx_ep,
  input logic              rx_setup,
  input logic [NUM_EP-1:0] ep_ready,
  input logic [1:0]        lock_q
);
  // R7: an accepted set-up locks both control endpoints and silences them
  assert_setup_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pkt && rx_setup && rx_ep == '0 && !lock_q[0] && !bus_rst)
      |=> (lock_q == 2'b11 && ep_ready[1:0] == 2'b00));

  // R9: acknowledging the control IN endpoint removes its lock
  assert_ack_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_ACK && cmd_ep == EP_W'(1) && !(rx_pkt && rx_setup))
      |=> !lock_q[1]);

  // R10: an error pulse only follows an accepted command
  assert_err_follows_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid && cmd_ready));

  // R11: a pending response holds until taken
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status)));

  // R1: a bus reset leaves only the empty control OUT endpoint ready
  assert_busrst_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (ep_ready == NUM_EP'(1) && lock_q == 2'b00));
endmodule

bind usb_ep_handshake ephs_checker #(.NUM_EP(NUM_EP), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_rst    (bus_rst),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .cmd_ep     (cmd_ep),
  .cmd_err    (cmd_err),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_status (rsp_status),
  .rx_pkt     (rx_pkt),
  .rx_ep      (rx_ep),
  .rx_setup   (rx_setup),
  .ep_ready   (ep_ready),
  .lock_q     (lock_q)
);

// File: tb/usb_ep_handshake_bench.sv
`timescale 1ns/1ps
module usb_ep_handshake_bench;
  localparam int NE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [3:0] cmd_ep = '0;
  logic [9:0] cmd_len = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [15:0] rsp_status;
  logic       cmd_err;
  logic       rx_pkt = 1'b0;
  logic [3:0] rx_ep = '0;
  logic       rx_setup = 1'b0;
  logic [9:0] rx_len = '0;
  logic       tx_done = 1'b0;
  logic [3:0] tx_ep = '0;
  logic [15:0] ep_ready;

  always #2.5 clk = ~clk;

  usb_ep_handshake u_usb_ep_handshake (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_ep(cmd_ep), .cmd_len(cmd_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .cmd_err(cmd_err),
    .rx_pkt(rx_pkt), .rx_ep(rx_ep), .rx_setup(rx_setup), .rx_len(rx_len),
    .tx_done(tx_done), .tx_ep(tx_ep), .ep_ready(ep_ready)
  );

  // behavioural reference state
  bit    m_en[NE], m_in[NE], m_full[NE], m_irq[NE], m_stp[NE];
  int    m_len[NE];
  bit    m_lock[2];
  bit    m_rv, m_err;
  logic [15:0] m_rs;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit lk(int e);
    return (e < 2) ? m_lock[e] : 1'b0;
  endfunction

  function automatic logic [15:0] model_ready();
    logic [15:0] r = '0;
    for (int e = 0; e < NE; e++)
      r[e] = m_en[e] && !lk(e) && (m_in[e] ? m_full[e] : !m_full[e]);
    return r;
  endfunction

  task automatic model_reset();
    for (int e = 0; e < NE; e++) begin
      m_en[e] = (e < 2); m_in[e] = (e == 1);
      m_full[e] = 0; m_irq[e] = 0; m_stp[e] = 0; m_len[e] = 0;
    end
    m_lock[0] = 0; m_lock[1] = 0;
  endtask

  // next state from current inputs; evaluated before the rising edge
  task automatic model_step();
    bit o_en[NE], o_in[NE], o_full[NE];
    bit o_lock[2];
    bit acc, ok;
    int e;
    o_en = m_en; o_in = m_in; o_full = m_full; o_lock = m_lock;
    acc = cmd_valid && (!m_rv || rsp_ready);
    if (m_rv && rsp_ready) m_rv = 0;
    m_err = 0;
    if (acc) begin
      e = int'(cmd_ep);
      ok = 0;
      case (cmd_op)
        3'd0: if (e >= 2) begin
                ok = 1; m_en[e] = cmd_len[0]; m_in[e] = cmd_len[1];
                m_full[e] = 0; m_irq[e] = 0; m_stp[e] = 0; m_len[e] = 0;
              end
        3'd1, 3'd2: if (o_en[e]) begin
                ok = 1; m_rv = 1;
                m_rs = {m_stp[e], m_en[e], m_in[e], lk(e), m_irq[e], m_full[e], 10'(m_len[e])};
                if (cmd_op == 3'd2) m_irq[e] = 0;
              end
        3'd3: if (o_en[e] && !lk(e)) begin
                ok = 1; m_full[e] = 0; m_len[e] = 0; m_stp[e] = 0;
              end
        3'd4: if (o_en[e] && o_in[e] && !lk(e)) begin ok = 1; m_full[e] = 1; end
        3'd5: if (e < 2) begin ok = 1; m_lock[e] = 0; end
        3'd6: if (o_en[e] && o_in[e] && !o_full[e]) begin ok = 1; m_len[e] = int'(cmd_len); end
        default: ok = 0;
      endcase
      m_err = !ok;
    end
    if (rx_pkt && rx_setup && rx_ep == 0 && !o_lock[0]) begin
      m_full[0] = 1; m_irq[0] = 1; m_stp[0] = 1; m_len[0] = int'(rx_len);
      m_full[1] = 0; m_len[1] = 0;
      m_lock[0] = 1; m_lock[1] = 1;
    end
    if (rx_pkt && !rx_setup) begin
      e = int'(rx_ep);
      if (o_en[e] && !o_in[e] && !o_full[e] && !((e < 2) && o_lock[e])) begin
        m_full[e] = 1; m_irq[e] = 1; m_len[e] = int'(rx_len);
      end
    end
    if (tx_done) begin
      e = int'(tx_ep);
      if (o_en[e] && o_in[e] && o_full[e] && !((e < 2) && o_lock[e])) begin
        m_full[e] = 0; m_irq[e] = 1;
      end
    end
    if (bus_rst) model_reset();
  endtask

  task automatic compare();
    chk(cur_req, "ep_ready", 32'(ep_ready), 32'(model_ready()));
    chk("R10", "cmd_err", 32'(cmd_err), 32'(m_err));
    chk("R11", "rsp_valid", 32'(rsp_valid), 32'(m_rv));
    chk("R11", "cmd_ready", 32'(cmd_ready), 32'(!m_rv || rsp_ready));
    if (m_rv) chk("R6", "rsp_status", 32'(rsp_status), 32'(m_rs));
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    compare();
    cmd_valid = 0; rx_pkt = 0; rx_setup = 0; tx_done = 0; bus_rst = 0;
  endtask

  task automatic cmd(input int op, input int ep, input int len);
    cmd_valid = 1; cmd_op = 3'(op); cmd_ep = 4'(ep); cmd_len = 10'(len);
    cyc();
  endtask

  task automatic rx(input int ep, input int len, input bit stp);
    rx_pkt = 1; rx_ep = 4'(ep); rx_len = 10'(len); rx_setup = stp;
    cyc();
  endtask

  task automatic tx(input int ep);
    tx_done = 1; tx_ep = 4'(ep);
    cyc();
  endtask

  initial begin
    model_reset();
    m_rv = 0; m_err = 0; m_rs = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    cur_req = "R1";
    chk("R1", "ep_ready after reset", 32'(ep_ready), 32'h0001);
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);

    cur_req = "R2";
    cmd(0, 2, 1);          // ep2 OUT enabled
    cmd(0, 3, 3);          // ep3 IN enabled
    chk("R2", "ep2 ready, ep3 not", 32'(ep_ready), 32'h0005);
    cmd(0, 1, 3);          // configure control ep -> error
    chk("R10", "cfg ctrl err", 32'(cmd_err), 32'h1);
    cmd(2, 7, 0);          // status on disabled
    chk("R10", "disabled status err", 32'(cmd_err), 32'h1);
    cmd(7, 2, 0);
    chk("R10", "reserved opcode err", 32'(cmd_err), 32'h1);

    cur_req = "R3";
    rx(2, 64, 0);
    chk("R3", "ep2 not ready when full", 32'(ep_ready[2]), 32'h0);
    rx(2, 5, 0);           // ignored
    cmd(2, 2, 0);
    chk("R6", "ep2 status word", 32'(rsp_status), 32'h4C40);
    cmd(2, 2, 0);          // irq now cleared
    chk("R6", "irq cleared", 32'(rsp_status[11]), 32'h0);
    cmd(3, 2, 0);
    chk("R3", "ep2 ready after clear", 32'(ep_ready[2]), 32'h1);

    cur_req = "R4";
    cmd(6, 2, 9);          // write length to OUT -> error
    cmd(6, 3, 20);
    chk("R4", "ep3 not ready before validate", 32'(ep_ready[3]), 32'h0);
    cmd(4, 3, 0);
    chk("R5", "ep3 ready after validate", 32'(ep_ready[3]), 32'h1);
    cmd(6, 3, 30);         // full -> error
    tx(3);
    chk("R4", "ep3 drained", 32'(ep_ready[3]), 32'h0);

    cur_req = "R11";
    rsp_ready = 0;
    cmd(1, 3, 0);
    cmd(2, 2, 0);          // stalled
    cyc(); cyc();
    rsp_ready = 1;
    cyc();

    cur_req = "R7";
    cmd(6, 1, 8); cmd(4, 1, 0);
    rx(0, 8, 1);
    chk("R7", "control pair silent", 32'(ep_ready[1:0]), 32'h0);
    cur_req = "R8";
    cmd(3, 0, 0);
    chk("R8", "clear locked err", 32'(cmd_err), 32'h1);
    cmd(4, 1, 0);
    chk("R8", "validate locked err", 32'(cmd_err), 32'h1);
    rx(0, 3, 0); rx(0, 4, 1); tx(1);
    cmd(1, 0, 0);
    chk("R8", "setup kept", 32'(rsp_status), 32'hDC08);
    cur_req = "R9";
    cmd(5, 0, 0);
    cmd(3, 0, 0);
    chk("R9", "ep0 ready after ack+clear", 32'(ep_ready[0]), 32'h1);
    chk("R9", "ep1 still locked", 32'(ep_ready[1]), 32'h0);
    cmd(5, 6, 0);
    chk("R9", "ack on ep6 err", 32'(cmd_err), 32'h1);
    cmd(5, 1, 0);

    cur_req = "R12";
    cmd_valid = 1; cmd_op = 3'd2; cmd_ep = 4'd2; rx_pkt = 1; rx_ep = 4'd2; rx_len = 10'd17;
    cyc();
    cmd(1, 2, 0);
    chk("R12", "irq survives same-cycle status", 32'(rsp_status[11]), 32'h1);

    cur_req = "R1";
    bus_rst = 1; cyc();
    chk("R1", "bus reset ready", 32'(ep_ready), 32'h0001);

    cur_req = "R5";
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      rsp_ready = ($urandom_range(0, 3) != 0);
      if (r < 45) begin
        cmd_valid = 1; cmd_op = 3'($urandom_range(0, 7));
        cmd_ep = 4'($urandom_range(0, 15)); cmd_len = 10'($urandom_range(0, 1023));
      end
      if (r >= 30 && r < 70) begin
        rx_pkt = 1; rx_ep = 4'($urandom_range(0, 15)); rx_len = 10'($urandom_range(0, 1023));
        rx_setup = ($urandom_range(0, 7) == 0);
      end
      if (r >= 60 && r < 90) begin
        tx_done = 1; tx_ep = 4'($urandom_range(0, 15));
      end
      if (r == 99 && $urandom_range(0, 3) == 0) bus_rst = 1;
      cyc();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule